// File: doc/BRIEF.md
# Serial EEPROM Target on a Two-Wire Bus

This block is a two-wire serial-bus target that sits in front of a byte-wide storage array held in flip-flops. It takes SCL and SDA that have already been synchronised to the system clock. It pulls SDA low through a single open-drain output enable. A master addresses it with a control byte. It can then send a word address and data to program the array, or read the array back through one address pointer. That pointer is shared by reads and writes and persists between transactions.

Programming is deferred. Data bytes are collected in a small page buffer and are written to the array only when a stop condition closes the write. A self-timed busy period of `WRITE_CYCLES` clocks then begins. While busy, the target does not acknowledge any control byte, so a master can poll until the target answers. A write-protect input turns the whole array read-only.

The controller is one state machine. Its states are:
- `ST_IDLE`: ignoring the bus until a start condition.
- `ST_CTRL`: shifting in the control byte.
- `ST_CTRL_ACK`: acknowledging the control byte.
- `ST_ADDR` and `ST_ADDR_ACK`: receiving and acknowledging the word address.
- `ST_WDATA` and `ST_WDATA_ACK`: receiving and acknowledging data.
- `ST_RDATA`: driving a data byte.
- `ST_RACK`: sampling the master's acknowledge.

Its transitions are:
- A start condition goes to `ST_CTRL` from any state.
- A stop condition goes to `ST_IDLE` from any state.
- `ST_CTRL` goes to `ST_CTRL_ACK` on a matching control byte when not busy, and otherwise to `ST_IDLE`.
- `ST_CTRL_ACK` goes to `ST_RDATA` for a read or to `ST_ADDR` for a write.
- `ST_ADDR` goes to `ST_ADDR_ACK`, and `ST_ADDR_ACK` goes to `ST_WDATA`.
- `ST_WDATA` goes to `ST_WDATA_ACK` and back, once per data byte.
- `ST_RDATA` goes to `ST_RACK` after eight bits.
- `ST_RACK` goes to `ST_RDATA` on a master acknowledge and to `ST_IDLE` on a not-acknowledge.

Top module: `eeprom_i2c_target`

## Requirements
- R1: A control byte is acknowledged only when bits 7:4 equal `DEV_CODE` (default 4'b1010) and bits 3:1 equal `CHIP_SEL` (default 3'b000). Any other control byte leaves SDA released until the next start.
- R2: Control-byte bit 0 selects the direction: 1 reads, 0 writes. In a write, the first byte after the control byte is the word address; it is acknowledged and loaded into the pointer, and every following data byte is acknowledged.
- R3: Data reaches the array only when a stop ends a write that carried at least one complete data byte. A start before that stop discards the pending bytes. The committing stop starts a busy period of `WRITE_CYCLES` clocks.
- R4: No control byte is acknowledged during the busy period. Once it ends, control bytes are acknowledged normally.
- R5: With `wp_i` high, data bytes are still acknowledged, but the array is unchanged and no busy period starts.
- R6: After a byte at address n has been read or written, a read that sends no word address returns the byte at n+1.
- R7: A write that carries only a word address, followed by a repeated start and a read control byte, returns the byte at that address.
- R8: In a read, a master acknowledge (SDA low in the ninth clock) makes the next byte follow. A not-acknowledge ends the read with SDA released.
- R9: The 8-bit pointer wraps from 0xFF to 0x00, both in sequential reads and in writes.
- R10: A start or stop inside a byte aborts the transaction. A stop that comes after more than one bit of a new data byte has been clocked in commits nothing and starts no busy period.
- R11: The target raises its SDA drive only while SCL is low, and it holds an acknowledge for the whole ninth clock.
- R12: One write holds at most `PAGE_BYTES` data bytes at consecutive addresses. If more arrive, the oldest pending bytes are dropped and only the last `PAGE_BYTES` are written.
- R13: After reset, SDA is released, the pointer is 0x00 and every array byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised serial clock |
| sda_i | input | 1 | Synchronised serial data (wired line level) |
| wp_i | input | 1 | Write protect, high makes the array read-only |
| sda_oe_o | output | 1 | Open-drain enable, 1 pulls SDA low |

## Verification
The hardest situations to reach are the ones where a stop or start lands at an awkward point in a byte. Examples are a stop after a few bits of a data byte, a start in the middle of a byte, and a repeated start that follows completed data bytes. In each case the only visible effect is what does not happen later. The bench bit-bangs these bus sequences with a partial-byte task. It then proves the effect by polling at once, where an acknowledge shows no busy period was started. It also reads back the addresses concerned and compares them with a reference array kept in the bench.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } tgt_state_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/eeprom_bus_cond.sv
module eeprom_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise  = scl_i & ~scl_q;
    assign scl_fall  = ~scl_i & scl_q;
    assign start_evt = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_evt  = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
    parameter int ADDR_W     = 8,
    parameter int PAGE_BYTES = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  clear,
    input  logic                                  push,
    input  logic [ADDR_W-1:0]                     push_addr,
    input  logic [7:0]                            push_data,
    output logic [PAGE_BYTES-1:0]                 slot_vld,
    output logic [PAGE_BYTES-1:0][ADDR_W-1:0]     slot_addr,
    output logic [PAGE_BYTES-1:0][7:0]            slot_data
);
    localparam int IDX_W = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAGE_BYTES - 1);

    logic [IDX_W-1:0] wr_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_idx    <= '0;
            slot_vld  <= '0;
            slot_addr <= '0;
            slot_data <= '0;
        end else if (clear) begin
            wr_idx   <= '0;
            slot_vld <= '0;
        end else if (push) begin
            slot_vld[wr_idx]  <= 1'b1;
            slot_addr[wr_idx] <= push_addr;
            slot_data[wr_idx] <= push_data;
            wr_idx            <= (wr_idx == LAST_IDX) ? '0 : wr_idx + 1'b1;
        end
    end

endmodule

// File: rtl/eeprom_mem_array.sv
module eeprom_mem_array #(
    parameter int ADDR_W     = 8,
    parameter int PAGE_BYTES = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              commit,
    input  logic [PAGE_BYTES-1:0]             slot_vld,
    input  logic [PAGE_BYTES-1:0][ADDR_W-1:0] slot_addr,
    input  logic [PAGE_BYTES-1:0][7:0]        slot_data,
    input  logic [ADDR_W-1:0]                 raddr,
    output logic [7:0]                        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) cells[w] <= 8'h00;
        end else if (commit) begin
            for (int s = 0; s < PAGE_BYTES; s++) begin
                if (slot_vld[s]) cells[slot_addr[s]] <= slot_data[s];
            end
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/eeprom_wr_timer.sv
module eeprom_wr_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= CNT_W'(CYCLES);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy = (remain != '0);

endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target
    import eeprom_i2c_pkg::*;
#(
    parameter logic [3:0] DEV_CODE     = 4'b1010,
    parameter logic [2:0] CHIP_SEL     = 3'b000,
    parameter int         ADDR_W       = 8,
    parameter int         PAGE_BYTES   = 8,
    parameter int         WRITE_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    output logic sda_oe_o
);
    localparam logic [3:0] BITS_FULL = 4'd8;
    localparam logic [3:0] BITS_LAST = 4'd7;

    tgt_state_e state, nxt;

    logic              scl_rise, scl_fall, start_evt, stop_evt;
    logic [3:0]        bitcnt;
    logic [7:0]        shreg;
    logic              rw_q;
    logic [ADDR_W-1:0] ptr;
    logic              busy;
    logic              ctrl_ok;
    logic              byte_done;
    logic              buf_push;
    logic              buf_clear;
    logic              commit_en;
    logic [7:0]        rdata;

    logic [PAGE_BYTES-1:0]             slot_vld;
    logic [PAGE_BYTES-1:0][ADDR_W-1:0] slot_addr;
    logic [PAGE_BYTES-1:0][7:0]        slot_data;

    eeprom_bus_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    assign ctrl_ok   = (shreg[7:4] == DEV_CODE) && (shreg[3:1] == CHIP_SEL) && !busy;
    assign byte_done = scl_fall && (bitcnt == BITS_FULL);
    assign buf_push  = (state == ST_WDATA) && byte_done;
    assign buf_clear = start_evt || stop_evt;
    assign commit_en = stop_evt && (state == ST_WDATA) && (bitcnt <= 4'd1)
                       && (|slot_vld) && !wp_i;

    eeprom_page_buf #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_page (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (buf_clear),
        .push      (buf_push),
        .push_addr (ptr),
        .push_data (shreg),
        .slot_vld  (slot_vld),
        .slot_addr (slot_addr),
        .slot_data (slot_data)
    );

    eeprom_mem_array #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit_en),
        .slot_vld  (slot_vld),
        .slot_addr (slot_addr),
        .slot_data (slot_data),
        .raddr     (ptr),
        .rdata     (rdata)
    );

    eeprom_wr_timer #(
        .CYCLES (WRITE_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (commit_en),
        .busy  (busy)
    );

    // Next-state decision
    always_comb begin
        nxt = state;
        if (start_evt) begin
            nxt = ST_CTRL;
        end else if (stop_evt) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_CTRL:      if (byte_done) nxt = ctrl_ok ? ST_CTRL_ACK : ST_IDLE;
                ST_CTRL_ACK:  if (scl_fall) nxt = rw_q ? ST_RDATA : ST_ADDR;
                ST_ADDR:      if (byte_done) nxt = ST_ADDR_ACK;
                ST_ADDR_ACK:  if (scl_fall) nxt = ST_WDATA;
                ST_WDATA:     if (byte_done) nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) nxt = ST_WDATA;
                ST_RDATA:     if (scl_fall && bitcnt == BITS_LAST) nxt = ST_RACK;
                ST_RACK: begin
                    if (scl_rise && sda_i) nxt = ST_IDLE;
                    else if (scl_fall)     nxt = ST_RDATA;
                end
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Shifter, bit counter and pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt <= '0;
            shreg  <= '0;
            rw_q   <= 1'b0;
            ptr    <= '0;
        end else if (start_evt || stop_evt) begin
            bitcnt <= '0;
        end else begin
            unique case (state)
                ST_CTRL, ST_ADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[6:0], sda_i};
                        bitcnt <= bitcnt + 1'b1;
                    end
                    if (byte_done) begin
                        if (state == ST_CTRL)  rw_q <= shreg[0];
                        if (state == ST_ADDR)  ptr  <= shreg[ADDR_W-1:0];
                        if (state == ST_WDATA) ptr  <= ptr + 1'b1;
                    end
                end
                ST_CTRL_ACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (rw_q) begin
                            shreg <= rdata;
                            ptr   <= ptr + 1'b1;
                        end
                    end
                end
                ST_ADDR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) bitcnt <= '0;
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        shreg  <= {shreg[6:0], 1'b0};
                        bitcnt <= bitcnt + 1'b1;
                    end
                end
                ST_RACK: begin
                    if (scl_rise && !sda_i) begin
                        shreg <= rdata;
                        ptr   <= ptr + 1'b1;
                    end
                    if (scl_fall) bitcnt <= '0;
                end
                default: bitcnt <= bitcnt;
            endcase
        end
    end

    // Output drive
    always_comb begin
        unique case (state)
            ST_CTRL_ACK, ST_ADDR_ACK, ST_WDATA_ACK: sda_oe_o = 1'b1;
            ST_RDATA:                               sda_oe_o = ~shreg[7];
            default:                                sda_oe_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/eeprom_i2c_chk.sv
module eeprom_i2c_chk
    import eeprom_i2c_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       wp_i,
    input logic       sda_oe,
    input logic       busy,
    input logic       commit,
    input logic       stop_evt,
    input logic       start_evt,
    input tgt_state_e state
);
    // R4
    busy_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);

    // R11
    drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    // R5
    protect_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !wp_i);

    // R3
    commit_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> stop_evt);

    // R3
    busy_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_evt));

    // R10
    start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> state == ST_CTRL);

endmodule

bind eeprom_i2c_target eeprom_i2c_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .wp_i      (wp_i),
    .sda_oe    (sda_oe_o),
    .busy      (busy),
    .commit    (commit_en),
    .stop_evt  (stop_evt),
    .start_evt (start_evt),
    .state     (state)
);

// File: tb/eeprom_i2c_target_tb.sv
module eeprom_i2c_target_tb;
    localparam int H          = 8;
    localparam int WCYC       = 400;
    localparam int PAGE       = 4;
    localparam logic [7:0] CW = 8'hA0;
    localparam logic [7:0] CR = 8'hA1;
    localparam logic [15:0] VEC [6] = '{16'h053C, 16'h06A7, 16'h805A,
                                        16'hFE11, 16'hFF22, 16'h0099};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_line;

    int checks = 0;
    int fails = 0;
    logic [7:0] mdl [256];
    logic [7:0] mptr = 8'h00;
    logic ack_early, ack_late;

    always #5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    eeprom_i2c_target #(
        .PAGE_BYTES   (PAGE),
        .WRITE_CYCLES (WCYC)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .wp_i     (wp),
        .sda_oe_o (sda_oe)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hold(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        scl = 1'b0; hold(H);
        sda_m = 1'b1; hold(H);
        scl = 1'b1; hold(H);
        sda_m = 1'b0; hold(H);
        scl = 1'b0;
    endtask

    task automatic bus_stop();
        scl = 1'b0;
        sda_m = 1'b0; hold(H);
        scl = 1'b1; hold(H);
        sda_m = 1'b1; hold(H);
    endtask

    task automatic send_bits(logic [7:0] b, int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; hold(H);
            scl = 1'b1; hold(H);
            scl = 1'b0;
        end
    endtask

    task automatic send_byte(logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; hold(H);
        scl = 1'b1; hold(2);
        ack_early = sda_oe;
        hold(H - 3);
        ack = ~sda_line;
        ack_late = sda_oe;
        hold(1);
        scl = 1'b0;
    endtask

    task automatic recv_byte(logic mack, output logic [7:0] d);
        sda_m = 1'b1;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            hold(H);
            scl = 1'b1; hold(H / 2);
            d = {d[6:0], sda_line};
            hold(H / 2);
            scl = 1'b0;
        end
        sda_m = ~mack; hold(H);
        scl = 1'b1; hold(H);
        scl = 1'b0;
        mptr = mptr + 8'd1;
    endtask

    task automatic write_one(logic [7:0] a, logic [7:0] d);
        logic k1, k2, k3;
        bus_start();
        send_byte(CW, k1);
        send_byte(a, k2);
        send_byte(d, k3);
        bus_stop();
        check("R2 write acks", {k1, k2, k3}, 3'b111);
        if (!wp) mdl[a] = d;
        mptr = a + 8'd1;
    endtask

    task automatic poll(output int tries);
        logic k;
        tries = 0;
        do begin
            tries++;
            bus_start();
            send_byte(CW, k);
            bus_stop();
        end while (!k && tries < 40);
    endtask

    task automatic rand_read(logic [7:0] a, output logic [7:0] d);
        logic k1, k2, k3;
        bus_start();
        send_byte(CW, k1);
        send_byte(a, k2);
        mptr = a;
        bus_start();
        send_byte(CR, k3);
        recv_byte(1'b0, d);
        bus_stop();
        check("R7 random read acks", {k1, k2, k3}, 3'b111);
    endtask

    task automatic cur_read(output logic [7:0] d);
        logic k;
        bus_start();
        send_byte(CR, k);
        recv_byte(1'b0, d);
        bus_stop();
        check("R6 current read ack", k, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d, exp;
        logic k;
        int tries;
        for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
        hold(5);
        rst_n = 1'b1;
        hold(5);

        // R13 reset state
        check("R13 sda released after reset", sda_oe, 1'b0);
        cur_read(d);
        check("R13 pointer and array zero", d, 8'h00);

        // R1 wrong chip select and wrong device code
        bus_start(); send_byte({4'hA, 3'b101, 1'b0}, k); bus_stop();
        check("R1 chip select mismatch nack", k, 1'b0);
        bus_start(); send_byte({4'hB, 3'b000, 1'b0}, k); bus_stop();
        check("R1 device code mismatch nack", k, 1'b0);

        // Vector table: write, poll, read back
        for (int v = 0; v < 6; v++) begin
            write_one(VEC[v][15:8], VEC[v][7:0]);
            poll(tries);
            check("R4 busy poll refused first", tries > 1, 1'b1);
            check("R4 poll acked after busy", tries < 40, 1'b1);
            rand_read(VEC[v][15:8], d);
            check("R3 committed byte", d, VEC[v][7:0]);
        end

        // R11 acknowledge held over ninth clock
        check("R11 ack whole ninth clock", {ack_early, ack_late}, 2'b11);

        // R8 R9 sequential read through wrap
        bus_start(); send_byte(CW, k); send_byte(8'hFE, k);
        mptr = 8'hFE;
        bus_start(); send_byte(CR, k);
        recv_byte(1'b1, d); check("R8 sequential byte 0", d, 8'h11);
        recv_byte(1'b1, d); check("R9 byte at 0xFF", d, 8'h22);
        recv_byte(1'b0, d); check("R9 wrapped to 0x00", d, 8'h99);
        bus_stop();
        check("R8 released after nack", sda_oe, 1'b0);

        // R6 current read after read
        exp = mdl[mptr];
        cur_read(d);
        check("R6 read follows last read", d, exp);

        // R6 current read after write
        write_one(8'h04, 8'h66);
        poll(tries);
        cur_read(d);
        check("R6 read follows last write", d, mdl[8'h05]);

        // R5 write protect
        wp = 1'b1;
        write_one(8'h80, 8'hEE);
        bus_start(); send_byte(CW, k); bus_stop();
        check("R5 no busy under protect", k, 1'b1);
        wp = 1'b0;
        rand_read(8'h80, d);
        check("R5 array unchanged", d, 8'h5A);

        // R3 repeated start discards pending data
        bus_start(); send_byte(CW, k); send_byte(8'h06, k); send_byte(8'hF0, k);
        bus_start(); bus_stop();
        bus_start(); send_byte(CW, k); bus_stop();
        check("R3 no busy after discard", k, 1'b1);
        rand_read(8'h06, d);
        check("R3 discarded data not written", d, 8'hA7);

        // R12 page overflow keeps the last PAGE bytes
        bus_start(); send_byte(CW, k); send_byte(8'h40, k);
        for (int i = 0; i < PAGE + 2; i++) send_byte(8'hB0 + 8'(i), k);
        bus_stop();
        for (int i = 2; i < PAGE + 2; i++) mdl[8'h40 + 8'(i)] = 8'hB0 + 8'(i);
        poll(tries);
        rand_read(8'h40, d); check("R12 oldest byte dropped", d, 8'h00);
        rand_read(8'h41, d); check("R12 second byte dropped", d, 8'h00);
        rand_read(8'h42, d); check("R12 kept byte", d, 8'hB2);
        rand_read(8'h45, d); check("R12 last byte", d, 8'hB5);

        // R10 stop inside a data byte commits nothing
        bus_start(); send_byte(CW, k); send_byte(8'h30, k);
        send_bits(8'hFF, 4);
        bus_stop();
        bus_start(); send_byte(CW, k); bus_stop();
        check("R10 no busy after aborted byte", k, 1'b1);
        rand_read(8'h30, d);
        check("R10 aborted byte not written", d, 8'h00);

        // R10 start inside a byte restarts at control byte
        bus_start(); send_byte(CW, k);
        send_bits(8'hC0, 3);
        exp = mdl[mptr];
        bus_start(); send_byte(CR, k);
        check("R10 control byte after mid-byte start", k, 1'b1);
        recv_byte(1'b0, d);
        bus_stop();
        check("R10 pointer kept over abort", d, exp);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule